// File: doc/BRIEF.md
# Register write-hazard scoreboard

This block keeps one pending-write bit per architectural register so that a core can let instructions overlap. When an instruction issues, its destination registers (up to `NWP` write ports) set their bits. Each function unit keeps its own copy of the register numbers it reads and writes. When a unit signals writeback on one of its write ports, the matching bit clears. A bit clears in preference to being set when both happen in the same cycle. The bits feed three checks. Issue stalls on a write-after-write conflict. Issue also waits behind units that must run alone. Each read port's picker ignores requests whose source register is still waiting for a write.

Every read port has a lowest-index-first picker. The hazard mask is applied to the picker's requests, so a blocked unit never holds back an unblocked one. Register data returns one clock after a read is granted, so the go-read pulse to a unit is the grant delayed by one cycle. When overlap is switched off, the scoreboard stays out of the way and issue never stalls.

Top module: `reg_wr_scoreboard`

## Requirements
- R1: After reset every pending bit is 0, no go-read pulse is present, and with no unit busy an offered issue is accepted (`iss_ready`=1).
- R2: With overlap on, an accepted issue sets the pending bit of each enabled destination (`iss_wr_en[w]`, register `iss_wr_reg[w*RW+:RW]`), visible on `pend` after the next edge. The write ports are OR-merged, so neither overrides the other.
- R3: A `wb_done[f*NWP+w]` pulse clears the bit of the register that unit f latched on write port w. A bit that is set and cleared in the same cycle ends up clear.
- R4: With overlap on, an offered issue whose enabled destination has its bit set, and is not being cleared in that cycle, is refused (`iss_ready`=0, `stall`=1). Issue is accepted again once the bit clears.
- R5: A unit's request on read port p is masked while the source register it latched for port p has a pending write. The mask includes a bit being set by an issue in the same cycle, and it lifts in the cycle of the clearing writeback.
- R6: On each read port, `rd_grant[p*NFU+f]` goes to the lowest-indexed unmasked requester, at most one per port. A masked unit of lower index does not stop a higher index from being granted.
- R7: `go_rd` equals `rd_grant` delayed by exactly one clock.
- R8: With overlap on, issue is refused while a unit in `SER_MASK` is busy, while the issue is marked `iss_serial` and any unit is busy, or while the target unit `iss_fu` is busy.
- R9: With overlap off, `iss_ready` is always 1 and issue sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| overlap_en | input | 1 | 1 enables overlapped issue and hazard tracking |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_ready | output | 1 | The offered instruction is accepted this cycle |
| stall | output | 1 | Offered but refused |
| iss_fu | input | FW | Target function unit index |
| iss_serial | input | 1 | Instruction must not overlap anything |
| iss_wr_en | input | NWP | Per-write-port destination enable |
| iss_wr_reg | input | NWP*RW | Destination register numbers |
| iss_rd_en | input | NRP | Per-read-port source enable |
| iss_rd_reg | input | NRP*RW | Source register numbers |
| fu_busy | input | NFU | Function unit busy flags |
| wb_done | input | NFU*NWP | Writeback pulse, unit f port w at bit f*NWP+w |
| rd_req | input | NRP*NFU | Read request, port p unit f at bit p*NFU+f |
| rd_grant | output | NRP*NFU | Picker grant, same layout |
| go_rd | output | NRP*NFU | Grant delayed one clock |
| pend | output | NREG | Pending-write bits |

## Verification
Issue and writeback can hit the same register in one cycle. The bench retires a unit's write to a register while another unit issues a new write to that same register. It then checks that the issue was accepted, because the old bit is leaving, and that the bit ends clear, because clear wins. A second collision pairs an issue that sets a register with a read request from a unit sourcing it. The request must be masked in that very cycle and the grant must pass to the next requester. Sweeps over all registers and all request patterns supply the expected values arithmetically.

// File: rtl/reg_wr_scoreboard.sv
module reg_wr_scoreboard #(
  parameter int NREG = 32,
  parameter int NWP = 2,
  parameter int NRP = 3,
  parameter int NFU = 4,
  parameter int SER_MASK = 8,
  localparam int RW = $clog2(NREG),
  localparam int FW = $clog2(NFU)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                overlap_en,
  input  logic                iss_valid,
  output logic                iss_ready,
  output logic                stall,
  input  logic [FW-1:0]       iss_fu,
  input  logic                iss_serial,
  input  logic [NWP-1:0]      iss_wr_en,
  input  logic [NWP*RW-1:0]   iss_wr_reg,
  input  logic [NRP-1:0]      iss_rd_en,
  input  logic [NRP*RW-1:0]   iss_rd_reg,
  input  logic [NFU-1:0]      fu_busy,
  input  logic [NFU*NWP-1:0]  wb_done,
  input  logic [NRP*NFU-1:0]  rd_req,
  output logic [NRP*NFU-1:0]  rd_grant,
  output logic [NRP*NFU-1:0]  go_rd,
  output logic [NREG-1:0]     pend
);
  localparam logic [NFU-1:0] SERM = NFU'(SER_MASK);

  logic [NREG-1:0] pend_q, set_v, clr_v, pend_now;
  logic [RW-1:0]   wreg [NFU][NWP];
  logic [NWP-1:0]  wval [NFU];
  logic [RW-1:0]   rreg [NFU][NRP];
  logic [NRP-1:0]  rval [NFU];
  logic [NRP*NFU-1:0] blk, go_q;
  logic waw, fire, accept;

  assign accept = iss_valid & iss_ready;
  assign fire   = accept & overlap_en;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    waw   = 1'b0;
    for (int w = 0; w < NWP; w++)
      if (fire && iss_wr_en[w]) set_v[iss_wr_reg[w*RW +: RW]] = 1'b1;
    for (int f = 0; f < NFU; f++)
      for (int w = 0; w < NWP; w++)
        if (wval[f][w] && wb_done[f*NWP+w]) clr_v[wreg[f][w]] = 1'b1;
    for (int w = 0; w < NWP; w++)
      if (iss_wr_en[w] && pend_q[iss_wr_reg[w*RW +: RW]] && !clr_v[iss_wr_reg[w*RW +: RW]])
        waw = 1'b1;
  end

  assign pend_now  = (pend_q | set_v) & ~clr_v;
  assign iss_ready = !overlap_en ||
                     !(waw || |(fu_busy & SERM) || (iss_serial && |fu_busy) || fu_busy[iss_fu]);
  assign stall     = iss_valid & ~iss_ready;
  assign pend      = pend_q;
  assign go_rd     = go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NFU; f++) begin
        wval[f] <= '0;
        rval[f] <= '0;
        for (int w = 0; w < NWP; w++) wreg[f][w] <= '0;
        for (int p = 0; p < NRP; p++) rreg[f][p] <= '0;
      end
    end else begin
      for (int f = 0; f < NFU; f++) begin
        wval[f] <= wval[f] & ~wb_done[f*NWP +: NWP];
        if (accept && iss_fu == FW'(f)) begin
          wval[f] <= iss_wr_en;
          rval[f] <= iss_rd_en;
          for (int w = 0; w < NWP; w++) wreg[f][w] <= iss_wr_reg[w*RW +: RW];
          for (int p = 0; p < NRP; p++) rreg[f][p] <= iss_rd_reg[p*RW +: RW];
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NRP; p++)
      for (int f = 0; f < NFU; f++)
        blk[p*NFU+f] = overlap_en & rval[f][p] & pend_now[rreg[f][p]];
  end

  genvar gp, gf, gw;
  generate
    for (gp = 0; gp < NRP; gp++) begin : g_pick
      logic [NFU-1:0] cand;
      assign cand = rd_req[gp*NFU +: NFU] & ~blk[gp*NFU +: NFU];
      assign rd_grant[gp*NFU +: NFU] = cand & (~cand + 1'b1);

      a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_grant[gp*NFU +: NFU]));
      a_r6_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant[gp*NFU +: NFU] & ~rd_req[gp*NFU +: NFU]) == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) go_q <= '0;
    else        go_q <= rd_grant;
  end

  generate
    for (gf = 0; gf < NFU; gf++) begin : g_fu
      for (gw = 0; gw < NWP; gw++) begin : g_wp
        a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
          (wval[gf][gw] && wb_done[gf*NWP+gw]) |=> !pend_q[$past(wreg[gf][gw])]);
      end
    end
    for (gw = 0; gw < NWP; gw++) begin : g_set
      a_r2_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && iss_wr_en[gw] && !clr_v[iss_wr_reg[gw*RW +: RW]])
          |=> pend_q[$past(iss_wr_reg[gw*RW +: RW])]);
      a_r4_waw_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (overlap_en && iss_wr_en[gw] && pend_q[iss_wr_reg[gw*RW +: RW]] &&
         !clr_v[iss_wr_reg[gw*RW +: RW]]) |-> !iss_ready);
    end
  endgenerate

  a_r7_go_delay: assert property (@(posedge clk) disable iff (!rst_n)
    go_rd == $past(rd_grant));
  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap_en |-> iss_ready);
  a_r9_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap_en |=> (pend_q & ~$past(pend_q)) == '0);
  a_r8_ser_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (overlap_en && (fu_busy & SERM) != '0) |-> !iss_ready);
endmodule

// File: tb/reg_wr_scoreboard_tb.sv
module reg_wr_scoreboard_tb;
  localparam int CLK_P = 10;
  localparam int NREG = 32, NWP = 2, NRP = 3, NFU = 4, RW = 5, FW = 2;

  logic clk = 0, rst_n = 0, overlap_en = 1, iss_valid = 0, iss_serial = 0;
  logic iss_ready, stall;
  logic [FW-1:0] iss_fu = 0;
  logic [NWP-1:0] iss_wr_en = 0;
  logic [NWP*RW-1:0] iss_wr_reg = 0;
  logic [NRP-1:0] iss_rd_en = 0;
  logic [NRP*RW-1:0] iss_rd_reg = 0;
  logic [NFU-1:0] fu_busy = 0;
  logic [NFU*NWP-1:0] wb_done = 0;
  logic [NRP*NFU-1:0] rd_req = 0, rd_grant, go_rd;
  logic [NREG-1:0] pend;
  int checks = 0, fails = 0;
  logic [NRP*NFU-1:0] exp_g;

  always #(CLK_P/2) clk = ~clk;

  reg_wr_scoreboard #(.NREG(NREG), .NWP(NWP), .NRP(NRP), .NFU(NFU), .SER_MASK(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .overlap_en(overlap_en), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .stall(stall), .iss_fu(iss_fu), .iss_serial(iss_serial),
    .iss_wr_en(iss_wr_en), .iss_wr_reg(iss_wr_reg), .iss_rd_en(iss_rd_en),
    .iss_rd_reg(iss_rd_reg), .fu_busy(fu_busy), .wb_done(wb_done), .rd_req(rd_req),
    .rd_grant(rd_grant), .go_rd(go_rd), .pend(pend));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 0; iss_serial = 0; iss_wr_en = 0; iss_rd_en = 0;
    wb_done = 0; rd_req = 0;
  endtask

  task automatic offer(int fu, logic [1:0] wen, int r0, int r1);
    iss_valid = 1; iss_fu = FW'(fu); iss_wr_en = wen;
    iss_wr_reg = {RW'(r1), RW'(r0)};
  endtask

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); step(); rst_n = 1; step();
    // R1 reset state
    chk("R1 pend", 64'(pend), 0);
    chk("R1 go", 64'(go_rd), 0);
    offer(0, 2'b01, 4, 0); #1;
    chk("R1 ready", 64'(iss_ready), 1);
    idle(); #1;

    // R2/R4/R3 sweep over all registers
    for (int r = 0; r < NREG; r++) begin
      offer(0, 2'b01, r, 0); step(); idle();
      chk("R2 set", 64'(pend), 64'(32'd1 << r));
      offer(1, 2'b01, r, 0); #1;
      chk("R4 waw refuse", 64'({iss_ready, stall}), 64'b01);
      offer(1, 2'b10, 0, (r + 1) % NREG); #1;
      chk("R4 other reg ok", 64'(iss_ready), 1);
      idle(); wb_done[0] = 1; step(); idle();
      chk("R3 clear", 64'(pend), 0);
    end

    // R2 two ports merged
    offer(1, 2'b11, 5, 9); step(); idle();
    chk("R2 two ports", 64'(pend), 64'((32'd1 << 5) | (32'd1 << 9)));
    offer(2, 2'b11, 5, 5); #1;
    chk("R4 dup dest", 64'(iss_ready), 0);
    idle(); wb_done[1*NWP+1] = 1; step(); idle();
    chk("R3 port1 only", 64'(pend), 64'(32'd1 << 5));
    wb_done[1*NWP+0] = 1; step(); idle();
    chk("R3 port0", 64'(pend), 0);

    // R3 clear wins against same-cycle set
    offer(0, 2'b01, 7, 0); step(); idle();
    offer(1, 2'b01, 7, 0); wb_done[0] = 1; #1;
    chk("R4 ready while clearing", 64'(iss_ready), 1);
    step(); idle();
    chk("R3 clear wins", 64'(pend), 0);
    wb_done[1*NWP] = 1; step(); idle();

    // R6/R7 picker sweep
    for (int p = 0; p < NRP; p++)
      for (int m = 0; m < 16; m++) begin
        rd_req = 12'(m) << (p*NFU);
        exp_g = 0;
        for (int b = 3; b >= 0; b--) if (m[b]) exp_g = 12'(1) << (p*NFU + b);
        #1; chk("R6 grant", 64'(rd_grant), 64'(exp_g));
        step();
        chk("R7 go delay", 64'(go_rd), 64'(exp_g));
      end
    idle(); step();

    // R5 read block with same-cycle visibility
    iss_valid = 1; iss_fu = 0; iss_rd_en = 3'b001; iss_rd_reg = 15'd20; step(); idle();
    offer(2, 2'b01, 20, 0); rd_req = 12'b0011; #1;
    chk("R5 same-cycle mask", 64'(rd_grant), 64'b0010);
    step(); iss_valid = 0; iss_wr_en = 0; #1;
    chk("R5 still masked", 64'(rd_grant), 64'b0010);
    rd_req = 12'b0001; #1;
    chk("R6 blocked only", 64'(rd_grant), 0);
    wb_done[2*NWP] = 1; #1;
    chk("R5 lifts at writeback", 64'(rd_grant), 64'b0001);
    step(); idle(); step();

    // R8 serialisation
    fu_busy = 4'b1000; offer(0, 2'b00, 0, 0); #1;
    chk("R8 serial unit busy", 64'(iss_ready), 0);
    fu_busy = 4'b0001; offer(2, 2'b00, 0, 0); iss_serial = 1; #1;
    chk("R8 serial issue", 64'(iss_ready), 0);
    iss_serial = 0; #1;
    chk("R8 plain issue", 64'(iss_ready), 1);
    fu_busy = 4'b0100; #1;
    chk("R8 target busy", 64'(iss_ready), 0);
    idle(); fu_busy = 0;

    // R9 bypass
    overlap_en = 0; fu_busy = 4'b1111; offer(0, 2'b01, 3, 0); iss_serial = 1; #1;
    chk("R9 ready", 64'(iss_ready), 1);
    step(); idle(); fu_busy = 0;
    chk("R9 no set", 64'(pend), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule